// File: doc/BRIEF.md
# Dual-mode photon gate shaper

This block sits in each pixel between a single-photon detector and a charge integrator. It turns detector events into one gating pulse. Timing is set by a global reference clock and a window enable. In counting mode, every accepted event yields a gate exactly one reference period long. The gate starts on the first reference rising edge after the event, so the charge held on the integrator grows in equal steps per photon. In timing mode, only the first event of a window is taken. Its gate runs from the detected event until the next falling edge of the reference clock, so the charge measures how long that photon arrived before the clock edge.

The block runs on a fast sampling clock. The asynchronous event line passes through a configurable synchronizer. The reference clock and the window enable are treated as levels that are synchronous to the sampling clock. An event that arrives while a gate is pending or active cannot be counted. It is dropped and raises a sticky overrun flag, which stays set until the next window opens.

Top module: `pulse_shaper`

## Requirements
- R1: While reset is asserted, and after it is released with no event seen, `gate_o` and `ovr_o` are low.
- R2: An event edge on `evt_i` that is first sampled at clock edge e is acted on at decision edge e+SYNC_STAGES. A timing-mode gate goes high after that edge.
- R3: In timing mode (`mode_i`=1), the gate stays high from the decision edge until the first clock edge after it at which `ref_i` is low and was high on the previous edge (a reference fall). The gate is low after that edge.
- R4: In counting mode (`mode_i`=0), the gate rises at the first reference rise (`ref_i` high, previously low) strictly after the decision edge. It falls at the next reference rise, so it lasts one full reference period.
- R5: In timing mode, only the first accepted event of a window makes a gate. Later events in the same window that find the block idle make no gate and do not set `ovr_o`. A new window (a low-to-high change of `win_en_i`) re-arms the block.
- R6: An event whose decision edge finds a gate pending or active is dropped and makes no extra gate.
- R7: `ovr_o` rises after the edge at which an event is dropped and stays high. It clears at the edge where `win_en_i` goes high again, unless a drop happens in that same cycle.
- R8: An event whose decision edge sees `win_en_i` low is ignored in both modes. It makes no gate and does not touch `ovr_o`.
- R9: The mode is captured when an event is accepted. Changing `mode_i` while that gate is pending or active does not change the gate's length.
- R10: In counting mode, events whose decision edges are at least two reference periods plus one clock apart are all accepted, each with its own full-period gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Asynchronous detector event, rising edge significant |
| ref_i | input | 1 | Global reference clock level, synchronous to clk_i |
| mode_i | input | 1 | 1 = arrival timing, 0 = event counting |
| win_en_i | input | 1 | Observation window enable; a rising change opens a window |
| gate_o | output | 1 | Gate to the charge integrator |
| ovr_o | output | 1 | Sticky flag: an event was dropped in this window |

## Verification
The bench places a single event at each of the four sampling phases of the reference clock in both modes. It compares every sampled gate cycle with edges worked out arithmetically, so an off-by-one in the synchronizer delay or a gate that ends on the wrong reference edge gives a mismatched cycle. It then targets the cases a sloppy design gets wrong. An event that lands during a pending counting gate must not retrigger. A second event in a timing window must be ignored silently rather than flagged. Events must be ignored when the window is closed. The flag must clear at the next window. A mode flip in the middle of a pulse must leave the pulse at its latched length. A design that took the live mode would shorten that pulse to half a period.

// File: rtl/pshp_pkg.sv
package pshp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_GATE  = 2'd2
  } pshp_state_e;

  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic fall_of(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

  // Edge that closes an open gate, chosen by the latched mode.
  function automatic logic gate_close(input logic tmode,
                                      input logic rref,
                                      input logic fref);
    return tmode ? fref : rref;
  endfunction

endpackage

// File: rtl/pshp_sync.sv
module pshp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pshp_edge.sv
module pshp_edge
  import pshp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = rise_of(lvl_i, prev_q);
  assign fall_o = fall_of(lvl_i, prev_q);
endmodule

// File: rtl/pshp_ctrl.sv
module pshp_ctrl
  import pshp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic win_en_i,
  input  logic win_start_i,
  input  logic evt_rise_i,
  input  logic ref_rise_i,
  input  logic ref_fall_i,
  output logic gate_o,
  output logic ovr_o,
  output logic acc_o,
  output logic drop_o,
  output logic tmode_o
);
  pshp_state_e state_q, state_d;
  logic tmode_q, taken_q, ovr_q;
  logic busy, evt_ok, taken_eff;

  assign busy      = (state_q != ST_IDLE);
  assign evt_ok    = evt_rise_i & win_en_i;
  assign taken_eff = taken_q & ~win_start_i;
  assign acc_o     = evt_ok & ~busy & ~(mode_i & taken_eff);
  assign drop_o    = evt_ok & busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (acc_o) state_d = mode_i ? ST_GATE : ST_ARMED;
      ST_ARMED: if (ref_rise_i) state_d = ST_GATE;
      ST_GATE:  if (gate_close(tmode_q, ref_rise_i, ref_fall_i)) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmode_q <= 1'b0;
      taken_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (acc_o) tmode_q <= mode_i;
      if (win_start_i)         taken_q <= acc_o & mode_i;
      else if (acc_o & mode_i) taken_q <= 1'b1;
      if (drop_o)           ovr_q <= 1'b1;
      else if (win_start_i) ovr_q <= 1'b0;
    end
  end

  assign gate_o  = (state_q == ST_GATE);
  assign ovr_o   = ovr_q;
  assign tmode_o = tmode_q;
endmodule

// File: rtl/pulse_shaper.sv
module pulse_shaper #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic ref_i,
  input  logic mode_i,
  input  logic win_en_i,
  output logic gate_o,
  output logic ovr_o
);
  logic evt_s;
  logic evt_rise_w, evt_fall_w;
  logic ref_rise_w, ref_fall_w;
  logic win_start_w, win_end_w;
  logic acc_w, drop_w, tmode_w;

  pshp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_i), .q_o(evt_s)
  );

  pshp_edge u_evt_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(evt_s),
    .rise_o(evt_rise_w), .fall_o(evt_fall_w)
  );

  pshp_edge u_ref_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(ref_i),
    .rise_o(ref_rise_w), .fall_o(ref_fall_w)
  );

  pshp_edge u_win_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(win_en_i),
    .rise_o(win_start_w), .fall_o(win_end_w)
  );

  pshp_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .win_en_i(win_en_i),
    .win_start_i(win_start_w), .evt_rise_i(evt_rise_w),
    .ref_rise_i(ref_rise_w), .ref_fall_i(ref_fall_w),
    .gate_o(gate_o), .ovr_o(ovr_o), .acc_o(acc_w), .drop_o(drop_w),
    .tmode_o(tmode_w)
  );
endmodule

// File: rtl/pshp_chk.sv
module pshp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic win_en_i,
  input logic gate_o,
  input logic ovr_o,
  input logic evt_rise_w,
  input logic ref_rise_w,
  input logic ref_fall_w,
  input logic win_start_w,
  input logic acc_w,
  input logic drop_w,
  input logic tmode_w
);
  AST_TIMING_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && tmode_w && ref_fall_w) |=> !gate_o); // R3

  AST_COUNT_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_o) && !tmode_w) |-> $past(ref_rise_w)); // R4

  AST_DROP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_w |=> ovr_o); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !win_start_w) |=> ovr_o); // R7

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_start_w && !drop_w) |=> !ovr_o); // R7

  AST_ACC_XOR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_w && drop_w)); // R6

  AST_WINDOW_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_rise_w && !win_en_i) |-> (!acc_w && !drop_w)); // R8

  AST_NO_REOPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && evt_rise_w) |-> !acc_w); // R6
endmodule

bind pulse_shaper pshp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_en_i(win_en_i),
  .gate_o(gate_o), .ovr_o(ovr_o), .evt_rise_w(evt_rise_w),
  .ref_rise_w(ref_rise_w), .ref_fall_w(ref_fall_w),
  .win_start_w(win_start_w), .acc_w(acc_w), .drop_w(drop_w),
  .tmode_w(tmode_w)
);

// File: tb/pulse_shaper_test.sv
module pulse_shaper_test;
  localparam int CLK_PERIOD = 10;
  localparam int S  = 2;
  localparam int RP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt = 1'b0, refc = 1'b1, mode_r = 1'b0, win = 1'b0;
  logic gate, ovr;

  int cyc = 0, checks = 0, fails = 0;
  int rises = 0, highs = 0;
  logic prev_g = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_shaper #(.SYNC_STAGES(S)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .ref_i(refc),
    .mode_i(mode_r), .win_en_i(win), .gate_o(gate), .ovr_o(ovr)
  );

  function automatic bit rv(int n);
    return (n % RP) < (RP / 2);
  endfunction

  function automatic bit exp_gate(bit m, int e, int k);
    int d, n, n1;
    d = e + S;
    if (k < d) return 1'b0;
    if (m) begin
      n = d + 1;
      while (!(!rv(n) && rv(n-1))) n++;
      return k < n;
    end
    n1 = d + 1;
    while (!(rv(n1) && !rv(n1-1))) n1++;
    n = n1 + 1;
    while (!(rv(n) && !rv(n-1))) n++;
    return (k >= n1) && (k < n);
  endfunction

  task automatic step(bit e, bit w);
    @(posedge clk);
    cyc = cyc + 1;
    @(negedge clk);
    if (gate && !prev_g) rises++;
    if (gate) highs++;
    prev_g = gate;
    evt  = e;
    win  = w;
    refc = rv(cyc + 1);
  endtask

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic new_window();
    step(0, 0); step(0, 0); step(0, 1); step(0, 1);
    rises = 0; highs = 0;
  endtask

  task automatic idle(int n, bit w);
    for (int i = 0; i < n; i++) step(0, w);
  endtask

  task automatic sweep(bit m, int ph);
    int e, err;
    mode_r = m;
    new_window();
    while (((cyc + 2) % RP) != ph) step(0, 1);
    e = cyc + 2;
    step(1, 1);
    err = 0;
    for (int i = 0; i < 16; i++) begin
      step(0, 1);
      if (gate !== exp_gate(m, e, cyc)) err++;
    end
    if (m) chk(err == 0, $sformatf("R2/R3 timing phase %0d mismatched cycles", ph), err, 0);
    else   chk(err == 0, $sformatf("R2/R4 count phase %0d mismatched cycles", ph), err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(0, 0); step(0, 0);
    chk(gate == 1'b0 && ovr == 1'b0, "R1 reset outputs", {gate, ovr}, 0);
    rst_n = 1'b1;
    idle(3, 0);
    chk(gate == 1'b0 && ovr == 1'b0, "R1 after release", {gate, ovr}, 0);

    for (int ph = 0; ph < RP; ph++) sweep(1'b1, ph);
    for (int ph = 0; ph < RP; ph++) sweep(1'b0, ph);

    // R6 / R7: second event lands while counting gate is pending or active
    mode_r = 1'b0;
    new_window();
    step(1, 1); idle(2, 1); step(1, 1); idle(16, 1);
    chk(rises == 1, "R6 one gate despite second event", rises, 1);
    chk(ovr == 1'b1, "R7 overrun set on drop", ovr, 1);
    idle(4, 1);
    chk(ovr == 1'b1, "R7 overrun sticky", ovr, 1);
    step(0, 0); step(0, 1); step(0, 1);
    chk(ovr == 1'b0, "R7 overrun cleared by new window", ovr, 0);

    // R5: timing mode takes only the first event
    mode_r = 1'b1;
    new_window();
    step(1, 1); idle(10, 1); step(1, 1); idle(10, 1);
    chk(rises == 1, "R5 single gate per window", rises, 1);
    chk(ovr == 1'b0, "R5 later event not flagged", ovr, 0);
    new_window();
    step(1, 1); idle(10, 1);
    chk(rises == 1, "R5 new window re-arms", rises, 1);

    // R8: window closed, both modes
    for (int m = 0; m < 2; m++) begin
      mode_r = m[0];
      idle(2, 0); rises = 0; highs = 0;
      step(1, 0); idle(10, 0);
      chk(rises == 0 && ovr == 1'b0, $sformatf("R8 closed window mode %0d", m), rises, 0);
    end

    // R9: mode flips mid-pulse, count gate keeps one full period
    mode_r = 1'b0;
    new_window();
    step(1, 1); idle(3, 1);
    mode_r = 1'b1;
    idle(12, 1);
    chk(rises == 1 && highs == RP, "R9 latched mode length", highs, RP);
    mode_r = 1'b0;

    // R10: widely spaced counting events all accepted
    new_window();
    for (int j = 0; j < 3; j++) begin
      step(1, 1); idle(11, 1);
    end
    idle(4, 1);
    chk(rises == 3 && highs == 3 * RP, "R10 every spaced event gated", highs, 3 * RP);
    chk(ovr == 1'b0, "R10 no overrun for spaced events", ovr, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule